// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block chooses which of eight interrupt request lines is presented to the processor. Each cycle it takes the current request, mask and in-service vectors. It finds the best pending line and the best line already in service, both measured against a rotating priority offset. It raises its interrupt output only when the pending line outranks everything in service.

The priority offset is held inside the block. It is changed by rotate commands that arrive on a single-cycle strobe. One command names a line explicitly. The other rotates around the highest-ranked line currently in service. After either command, the line just handled becomes the lowest priority.

Two mode inputs modify the in-service comparison. Special mask mode removes masked lines from the in-service set. Special fully nested mode is effective only when the block is built as a master. In that mode it ignores the in-service bit of the cascade line, so a second request from a downstream controller can still pass. Request latching, bus decoding and vector formation are handled by neighbouring blocks.

Top module: `rot_prio_resolver`

## Requirements
- R1: After reset, `irq_o` is 0, `line_o` is 0 and `offset_o` is 0, so line 0 has the highest priority.
- R2: A line is pending only when its request bit is 1 and its mask bit is 0. A masked request is never signalled.
- R3: The rank of line L is (L - offset) mod 8, where rank 0 is best. The line reported is the pending line with the best rank.
- R4: `irq_o` is 1 only when the best pending rank is strictly better than the best in-service rank. An empty in-service set ranks below every line, and an equal or worse pending rank gives no interrupt.
- R5: `irq_o` and `line_o` are registered. They show the result for the inputs and offset present at the previous clock edge, and `line_o` is 0 whenever `irq_o` is 0.
- R6: When `smask_i` is 1, in-service bits whose mask bit is 1 take no part in the in-service rank.
- R7: When `nested_i` is 1 on a master build, in-service bit `CASCADE_LINE` (line 2 by default) takes no part in the in-service rank.
- R8: A strobe with `rot_op_i` = 0 sets the offset to (`rot_line_i` + 1) mod 8 at the next edge.
- R9: A strobe with `rot_op_i` = 1 sets the offset to (L + 1) mod 8. L is the best-ranked line in the raw in-service vector, taken before any mode filtering and ranked with the current offset. When that vector is empty, the offset is left unchanged.
- R10: Without a strobe, the offset holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 8 | Request vector |
| mask_i | input | 8 | Mask vector (1 blocks a line) |
| insvc_i | input | 8 | In-service vector |
| smask_i | input | 1 | Special mask mode enable |
| nested_i | input | 1 | Special fully nested mode enable |
| rot_valid_i | input | 1 | Rotate command strobe |
| rot_op_i | input | 1 | 0: rotate on named line, 1: rotate on best in-service line |
| rot_line_i | input | 3 | Line named by a rotate command |
| irq_o | output | 1 | Registered interrupt request |
| line_o | output | 3 | Registered winning line, 0 when idle |
| offset_o | output | 3 | Current priority offset |

## Verification
The bench builds the block with its default values: eight lines, the master variant, and the cascade exclusion on line 2. These values bring the cascade exclusion of special fully nested mode within reach. Every offset value from 0 to 7, including the wrap from line 7 back to offset 0, can be reached through both rotate commands. A behavioural model recomputes the ranks with a plain modular search each cycle. Directed cases for equal ranks, empty sets and both special modes are followed by a long stretch of pseudo-random requests, masks and rotations.

// File: rtl/rot_prio_pkg.sv
package rot_prio_pkg;
   typedef enum logic {
      ROT_NAMED = 1'b0,
      ROT_INSVC = 1'b1
   } rot_op_e;
endpackage

// File: rtl/prio_rank_search.sv
module prio_rank_search #(
   parameter int N_LINES = 8,
   localparam int IDX_W  = $clog2(N_LINES),
   localparam int RANK_W = IDX_W + 1
) (
   input  logic [N_LINES-1:0] set_i,
   input  logic [IDX_W-1:0]   base_i,
   output logic               found_o,
   output logic [RANK_W-1:0]  rank_o,
   output logic [IDX_W-1:0]   line_o
);
   logic [N_LINES-1:0] rotated;

   // rotated[p] holds the line whose rank is p
   always_comb begin
      for (int p = 0; p < N_LINES; p++) begin
         rotated[p] = set_i[IDX_W'(IDX_W'(p) + base_i)];
      end
   end

   always_comb begin
      rank_o = RANK_W'(N_LINES);
      for (int p = N_LINES - 1; p >= 0; p--) begin
         if (rotated[p]) rank_o = RANK_W'(p);
      end
   end

   assign found_o = ~rank_o[IDX_W];
   assign line_o  = rank_o[IDX_W-1:0] + base_i;
endmodule

// File: rtl/prio_offset_reg.sv
module prio_offset_reg #(
   parameter int N_LINES = 8,
   localparam int IDX_W  = $clog2(N_LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rot_valid_i,
   input  logic             rot_op_i,
   input  logic [IDX_W-1:0] rot_line_i,
   input  logic             insvc_found_i,
   input  logic [IDX_W-1:0] insvc_line_i,
   output logic [IDX_W-1:0] offset_o
);
   import rot_prio_pkg::*;

   logic [IDX_W-1:0] offset_q;
   logic             upd;
   logic [IDX_W-1:0] pivot;

   always_comb begin
      upd   = 1'b0;
      pivot = rot_line_i;
      if (rot_valid_i) begin
         if (rot_op_e'(rot_op_i) == ROT_NAMED) begin
            upd = 1'b1;
         end else if (insvc_found_i) begin
            upd   = 1'b1;
            pivot = insvc_line_i;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   offset_q <= '0;
      else if (upd) offset_q <= pivot + 1'b1;
   end

   assign offset_o = offset_q;

   AST_OFFSET_NAMED: assert property (@(posedge clk) disable iff (!rst_n)
      (rot_valid_i && rot_op_i == 1'b0) |=> offset_o == $past(rot_line_i) + 1'b1); // R8
   AST_OFFSET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rot_valid_i |=> $stable(offset_o)); // R10
   AST_INSVC_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rot_valid_i && rot_op_i == 1'b1 && !insvc_found_i) |=> $stable(offset_o)); // R9
endmodule

// File: rtl/rot_prio_resolver.sv
module rot_prio_resolver #(
   parameter int N_LINES      = 8,
   parameter bit IS_MASTER    = 1'b1,
   parameter int CASCADE_LINE = 2,
   localparam int IDX_W       = $clog2(N_LINES),
   localparam int RANK_W      = IDX_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] req_i,
   input  logic [N_LINES-1:0] mask_i,
   input  logic [N_LINES-1:0] insvc_i,
   input  logic               smask_i,
   input  logic               nested_i,
   input  logic               rot_valid_i,
   input  logic               rot_op_i,
   input  logic [IDX_W-1:0]   rot_line_i,
   output logic               irq_o,
   output logic [IDX_W-1:0]   line_o,
   output logic [IDX_W-1:0]   offset_o
);
   initial begin
      if (N_LINES < 2 || (1 << IDX_W) != N_LINES)
         $error("N_LINES must be a power of two of at least 2");
      if (CASCADE_LINE < 0 || CASCADE_LINE >= N_LINES)
         $error("CASCADE_LINE must name an existing line");
   end

   logic [N_LINES-1:0] pend_w, ins_smask, ins_eff;
   logic               pend_found, ins_found, raw_found;
   logic [RANK_W-1:0]  pend_rank, ins_rank, raw_rank;
   logic [IDX_W-1:0]   pend_line, ins_line, raw_line;
   logic               want;
   logic               irq_q;
   logic [IDX_W-1:0]   line_q;

   assign pend_w    = req_i & ~mask_i;
   assign ins_smask = smask_i ? (insvc_i & ~mask_i) : insvc_i;

   generate
      if (IS_MASTER) begin : g_master
         always_comb begin
            ins_eff = ins_smask;
            if (nested_i) ins_eff[CASCADE_LINE] = 1'b0;
         end
      end else begin : g_slave
         assign ins_eff = ins_smask;
      end
   endgenerate

   prio_rank_search #(.N_LINES(N_LINES)) i_pend_search (
      .set_i(pend_w), .base_i(offset_o),
      .found_o(pend_found), .rank_o(pend_rank), .line_o(pend_line));

   prio_rank_search #(.N_LINES(N_LINES)) i_ins_search (
      .set_i(ins_eff), .base_i(offset_o),
      .found_o(ins_found), .rank_o(ins_rank), .line_o(ins_line));

   prio_rank_search #(.N_LINES(N_LINES)) i_raw_search (
      .set_i(insvc_i), .base_i(offset_o),
      .found_o(raw_found), .rank_o(raw_rank), .line_o(raw_line));

   prio_offset_reg #(.N_LINES(N_LINES)) i_offset (
      .clk(clk), .rst_n(rst_n),
      .rot_valid_i(rot_valid_i), .rot_op_i(rot_op_i), .rot_line_i(rot_line_i),
      .insvc_found_i(raw_found), .insvc_line_i(raw_line),
      .offset_o(offset_o));

   // none codes (N_LINES) sort below every real rank
   assign want = pend_found && (pend_rank < ins_rank);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q  <= 1'b0;
         line_q <= '0;
      end else begin
         irq_q  <= want;
         line_q <= want ? pend_line : '0;
      end
   end

   assign irq_o  = irq_q;
   assign line_o = line_q;

   logic unused_ok;
   assign unused_ok = ins_found ^ (|ins_line) ^ (|raw_rank);

   AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> |$past(pend_w)); // R2
   AST_LINE_WAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> |($past(pend_w) & (N_LINES'(1) << line_o))); // R2
   AST_IDLE_LINE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_o |-> line_o == '0); // R5
   AST_NO_PEND_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_w == '0) |=> !irq_o); // R4
endmodule

// File: tb/test_rot_prio_resolver.sv
module test_rot_prio_resolver;
   localparam int N = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] req = '0, mask = '0, insvc = '0;
   logic       smask = 1'b0, nested = 1'b0, rot_valid = 1'b0, rot_op = 1'b0;
   logic [2:0] rot_line = '0;
   logic       irq;
   logic [2:0] line, offset;

   int errors = 0, checks = 0;
   int m_off = 0, e_irq = 0, e_line = 0;

   always #4 clk = ~clk;

   rot_prio_resolver i_rot_prio_resolver (
      .clk(clk), .rst_n(rst_n), .req_i(req), .mask_i(mask), .insvc_i(insvc),
      .smask_i(smask), .nested_i(nested), .rot_valid_i(rot_valid),
      .rot_op_i(rot_op), .rot_line_i(rot_line),
      .irq_o(irq), .line_o(line), .offset_o(offset));

   function automatic int rk(logic [7:0] s, int off);
      for (int p = 0; p < N; p++) if (s[(p + off) % N]) return p;
      return N;
   endfunction

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic step(string tag);
      logic [7:0] pend, ins;
      int pr, cr, r;
      @(posedge clk);
      pend = req & ~mask;
      ins  = insvc;
      if (smask) ins = ins & ~mask;
      if (nested) ins[2] = 1'b0;
      pr = rk(pend, m_off);
      cr = rk(ins, m_off);
      if (pr < cr) begin e_irq = 1; e_line = (pr + m_off) % N; end
      else begin e_irq = 0; e_line = 0; end
      if (rot_valid) begin
         if (rot_op == 1'b0) m_off = (int'(rot_line) + 1) % N;
         else begin
            r = rk(insvc, m_off);
            if (r < N) m_off = ((r + m_off) % N + 1) % N;
         end
      end
      @(negedge clk);
      chk(tag, "irq", int'(irq), e_irq);
      chk(tag, "line", int'(line), e_line);
      chk(tag, "offset", int'(offset), m_off);
   endtask

   task automatic set_in(logic [7:0] r, logic [7:0] m, logic [7:0] s);
      req = r; mask = m; insvc = s;
   endtask

   task automatic rotate(logic op, logic [2:0] ln, string tag);
      rot_valid = 1'b1; rot_op = op; rot_line = ln;
      step(tag);
      rot_valid = 1'b0;
      step(tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1", "irq", int'(irq), 0);
      chk("R1", "line", int'(line), 0);
      chk("R1", "offset", int'(offset), 0);
      step("R1");

      // R2: masked request ignored, then unmasked
      set_in(8'h10, 8'h10, 8'h00); step("R2"); step("R2");
      set_in(8'h10, 8'h00, 8'h00); step("R2");
      // R5: one-cycle latency and idle line zero
      set_in(8'h00, 8'h00, 8'h00); step("R5");
      set_in(8'h40, 8'h00, 8'h00); step("R5"); step("R5");

      // R3 and R8: offset 0 then rotate on line 0
      set_in(8'h81, 8'h00, 8'h00); step("R3");
      rotate(1'b0, 3'd0, "R8"); step("R3");
      rotate(1'b0, 3'd7, "R8"); step("R3");

      // R4: equal and worse in-service ranks block
      set_in(8'h02, 8'h00, 8'h01); step("R4");
      set_in(8'h01, 8'h00, 8'h01); step("R4");
      set_in(8'h02, 8'h00, 8'h04); step("R4");

      // R6: special mask mode
      set_in(8'h08, 8'h01, 8'h01); step("R6");
      smask = 1'b1; step("R6"); step("R6");
      smask = 1'b0;

      // R7: special fully nested mode on the cascade line
      set_in(8'h08, 8'h00, 8'h04); step("R7");
      nested = 1'b1; step("R7"); step("R7");
      set_in(8'h04, 8'h00, 8'h04); step("R7");
      nested = 1'b0;

      // R9: rotate on best in-service, then empty set holds
      set_in(8'h00, 8'h00, 8'h30); rotate(1'b1, 3'd1, "R9");
      set_in(8'h00, 8'h00, 8'h00); rotate(1'b1, 3'd6, "R9");
      set_in(8'h21, 8'h00, 8'h00); step("R9");

      // R10 and mixed patterns
      for (int i = 0; i < 400; i++) begin
         req = 8'($urandom); mask = 8'($urandom & $urandom);
         insvc = 8'($urandom & $urandom & $urandom);
         smask = 1'($urandom); nested = 1'($urandom);
         rot_valid = ($urandom % 5) == 0; rot_op = 1'($urandom);
         rot_line = 3'($urandom);
         step("R10");
      end
      rot_valid = 1'b0;
      step("R10");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule